// File: doc/BRIEF.md
# Transmit 7-to-4 Serializer Gearbox

This block sits in front of a 4:1 double-data-rate output serializer in a source-synchronous transmitter. Each cycle of the pixel clock it accepts one 7-bit symbol for each data line. Each cycle of a second, related clock, running at one quarter of the line bit rate (7/4 of the pixel rate), it hands the serializer a 4-bit slice for each line. Seven slices carry exactly four pixel symbols, so the bit stream on every line is continuous.

The block also produces the slices for the forwarded clock line. That line carries a fixed 7-bit framing pattern each pixel period and travels the same buffer and slicing path as the data. Clock and data therefore change state at the same serial instants, and the clock line marks symbol boundaries at the receiver. A dual-clock buffer of eight entries with Gray-coded pointers carries whole pixel frames from the pixel domain to the slice domain. A build parameter selects how the flat input bus is split into per-line symbols.

Top module: `tx_gearbox_7to4`

## Requirements
- R1: Every pixel word that is written reaches the slice outputs exactly once, in order, with no gaps. After the last word of a burst, the bits that follow are the symbols of the later (zero) input words.
- R2: With `PACKING = PACK_BY_LANE`, the symbol of line l is `px_word[7*l+6 : 7*l]`.
- R3: With `PACKING = PACK_BY_SLOT`, bit b of the symbol of line l (b = 6 is sent first) is `px_word[b*LINES + l]`. Each group of LINES bits therefore holds one serial time slot for all lines.
- R4: Each 7-bit symbol goes out most significant bit first. Within each slice, bit 3 is the earliest serial bit. For line l that bit is `q_data[4*l+3]`.
- R5: The clock line `q_fclk` carries the pattern 1100011 (first bit sent on the left) once per symbol. Each pattern occupies the same serial bit positions as one data symbol on every line.
- R6: While `rst_n` is low, `q_data` and `q_fclk` are all zeros.
- R7: After reset release, the clock line runs from the first active slice cycle, and its first nonzero slice is 1100. The data lines stay zero until the buffer has held at least START_LEVEL (default 2) entries.
- R8: The buffer holds 8 frames. With the two clocks locked at a 4:7 ratio, its fill level never exceeds its depth, and no frame is overwritten before it is read.
- R9: Each clock domain releases the asynchronous reset through its own synchronizer. A reset applied in the middle of operation restarts both domains cleanly, and later traffic again meets R1 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| px_clk | input | 1 | Pixel clock, one symbol per line per cycle |
| q_clk | input | 1 | Slice clock at one quarter of the line bit rate |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| px_word | input | LINES*7 | Pixel word, split into line symbols according to PACKING |
| q_data | output | LINES*4 | Data slices for the serializer, 4 bits per line |
| q_fclk | output | 4 | Slice of the forwarded clock pattern |

## Verification
The bench builds two copies with LINES = 4, DEPTH = 8 and START_LEVEL = 2. One uses slot packing and the other lane packing, and both are driven by the same stimulus. The pixel and slice clock periods are 28 and 16 time units, locked at the 4:7 ratio, and they share rising edges every 112 units. This exposes the bursty four-loads-in-seven-cycles read cadence and pointer-synchronizer lag at the default start threshold. The bench rebuilds each serial stream, frames it on the clock line pattern and compares each symbol with the packing rule. A reset in mid-run, followed by a burst that starts shortly after release, exercises the restart path.

// File: rtl/tx_gbx_pkg.sv
package tx_gbx_pkg;

  localparam int SYM_W   = 7;
  localparam int SLICE_W = 4;

  localparam logic [SYM_W-1:0] FRAME_PAT = 7'b1100011;

  typedef enum logic {
    PACK_BY_SLOT = 1'b0,
    PACK_BY_LANE = 1'b1
  } pack_e;

endpackage

// File: rtl/tx_gbx_rst_sync.sv
module tx_gbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/tx_gbx_lane_pack.sv
module tx_gbx_lane_pack
  import tx_gbx_pkg::*;
#(
  parameter int    LINES   = 4,
  parameter pack_e PACKING = PACK_BY_SLOT,
  localparam int   IN_W    = LINES * SYM_W,
  localparam int   FRAME_W = (LINES + 1) * SYM_W
) (
  input  logic [IN_W-1:0]    px_word,
  output logic [FRAME_W-1:0] frame
);

  // Data lanes 0..LINES-1, forwarded clock lane on top.
  for (genvar l = 0; l < LINES; l++) begin : g_lane
    for (genvar b = 0; b < SYM_W; b++) begin : g_bit
      if (PACKING == PACK_BY_LANE) begin : g_by_lane
        assign frame[l*SYM_W + b] = px_word[l*SYM_W + b];
      end else begin : g_by_slot
        assign frame[l*SYM_W + b] = px_word[b*LINES + l];
      end
    end
  end

  assign frame[LINES*SYM_W +: SYM_W] = FRAME_PAT;

endmodule

// File: rtl/tx_gbx_cdc_fifo.sv
module tx_gbx_cdc_fifo #(
  parameter int  WIDTH = 35,
  parameter int  DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_pop,
  output logic [WIDTH-1:0] rd_data,
  output logic [PW-1:0]    rd_level
);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  logic [WIDTH-1:0] store_q [DEPTH];

  // ---------------- write domain ----------------
  logic [PW-1:0] wr_bin_q, wr_bin_d;
  logic [PW-1:0] wr_gray_q, wr_gray_d;
  logic          wr_en;

  always_comb begin
    wr_en     = wr_rst_n;
    wr_bin_d  = wr_bin_q + PW'(1);
    wr_gray_d = to_gray(wr_bin_d);
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wr_bin_q  <= '0;
      wr_gray_q <= '0;
    end else begin
      wr_bin_q  <= wr_bin_d;
      wr_gray_q <= wr_gray_d;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      store_q[wr_bin_q[AW-1:0]] <= wr_data;
    end
  end

  // ---------------- read domain -----------------
  logic [PW-1:0] wg_s1_q, wg_s2_q;
  logic [PW-1:0] rd_bin_q, rd_bin_d;

  always_comb begin
    rd_bin_d = rd_bin_q + {{(PW-1){1'b0}}, rd_pop};
    rd_level = from_gray(wg_s2_q) - rd_bin_q;
    rd_data  = store_q[rd_bin_q[AW-1:0]];
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      wg_s1_q  <= '0;
      wg_s2_q  <= '0;
      rd_bin_q <= '0;
    end else begin
      wg_s1_q  <= wr_gray_q;
      wg_s2_q  <= wg_s1_q;
      rd_bin_q <= rd_bin_d;
    end
  end

endmodule

// File: rtl/tx_gbx_slicer.sv
module tx_gbx_slicer
  import tx_gbx_pkg::*;
#(
  parameter int  LANES  = 5,
  localparam int BUF_W  = SYM_W + SLICE_W - 1,
  localparam int KEEP_W = BUF_W - SYM_W,
  localparam int CNT_W  = $clog2(BUF_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES*SYM_W-1:0]   load_word,
  output logic                     need_load,
  output logic [LANES*SLICE_W-1:0] slices
);

  logic [CNT_W-1:0] cnt_q, cnt_d, avail, shift;

  // Bits held are right-aligned; the oldest sits highest.
  always_comb begin
    need_load = (cnt_q < CNT_W'(SLICE_W));
    avail     = need_load ? cnt_q + CNT_W'(SYM_W) : cnt_q;
    shift     = avail - CNT_W'(SLICE_W);
    cnt_d     = shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BUF_W-1:0]   hold_q, hold_d;
    logic [SLICE_W-1:0] sl_q, sl_d;

    always_comb begin
      hold_d = need_load ? {hold_q[KEEP_W-1:0], load_word[g*SYM_W +: SYM_W]}
                         : hold_q;
      for (int k = 0; k < SLICE_W; k++) begin
        sl_d[k] = hold_d[int'(shift) + k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        sl_q   <= '0;
      end else begin
        hold_q <= hold_d;
        sl_q   <= sl_d;
      end
    end

    assign slices[g*SLICE_W +: SLICE_W] = sl_q;
  end

endmodule

// File: rtl/tx_gearbox_7to4.sv
module tx_gearbox_7to4
  import tx_gbx_pkg::*;
#(
  parameter int    LINES       = 4,
  parameter pack_e PACKING     = PACK_BY_SLOT,
  parameter int    DEPTH       = 8,
  parameter int    START_LEVEL = 2
) (
  input  logic                     px_clk,
  input  logic                     q_clk,
  input  logic                     rst_n,
  input  logic [LINES*SYM_W-1:0]   px_word,
  output logic [LINES*SLICE_W-1:0] q_data,
  output logic [SLICE_W-1:0]       q_fclk
);

  localparam int LANES   = LINES + 1;
  localparam int FRAME_W = LANES * SYM_W;
  localparam int LVL_W   = $clog2(DEPTH) + 1;
  localparam logic [LVL_W-1:0] START_LVL = LVL_W'(START_LEVEL);
  localparam logic [FRAME_W-1:0] IDLE_FRAME = {FRAME_PAT, {(LINES*SYM_W){1'b0}}};

  logic px_rst_n_s, q_rst_n_s;

  tx_gbx_rst_sync #(.STAGES(2)) u_px_rst (
    .clk    (px_clk),
    .arst_n (rst_n),
    .srst_n (px_rst_n_s)
  );

  tx_gbx_rst_sync #(.STAGES(2)) u_q_rst (
    .clk    (q_clk),
    .arst_n (rst_n),
    .srst_n (q_rst_n_s)
  );

  logic [FRAME_W-1:0] wr_frame;

  tx_gbx_lane_pack #(.LINES(LINES), .PACKING(PACKING)) u_pack (
    .px_word (px_word),
    .frame   (wr_frame)
  );

  logic [FRAME_W-1:0] rd_frame;
  logic [LVL_W-1:0]   rd_level;
  logic               pop;

  tx_gbx_cdc_fifo #(.WIDTH(FRAME_W), .DEPTH(DEPTH)) u_fifo (
    .wr_clk   (px_clk),
    .wr_rst_n (px_rst_n_s),
    .wr_data  (wr_frame),
    .rd_clk   (q_clk),
    .rd_rst_n (q_rst_n_s),
    .rd_pop   (pop),
    .rd_data  (rd_frame),
    .rd_level (rd_level)
  );

  logic               started_q, started_d;
  logic               need_load;
  logic [FRAME_W-1:0] load_word;
  logic [LANES*SLICE_W-1:0] slices;

  always_comb begin
    started_d = started_q | (rd_level >= START_LVL);
    pop       = need_load & started_q & (rd_level != '0);
    load_word = pop ? rd_frame : IDLE_FRAME;
  end

  always_ff @(posedge q_clk or negedge q_rst_n_s) begin
    if (!q_rst_n_s) begin
      started_q <= 1'b0;
    end else begin
      started_q <= started_d;
    end
  end

  tx_gbx_slicer #(.LANES(LANES)) u_slicer (
    .clk       (q_clk),
    .rst_n     (q_rst_n_s),
    .load_word (load_word),
    .need_load (need_load),
    .slices    (slices)
  );

  assign q_data = slices[LINES*SLICE_W-1:0];
  assign q_fclk = slices[LINES*SLICE_W +: SLICE_W];

endmodule

// File: rtl/tx_gearbox_7to4_chk.sv
module tx_gearbox_7to4_chk #(
  parameter int  LINES = 4,
  parameter int  DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic               q_clk,
  input logic               rst_n,
  input logic               q_rst_n_s,
  input logic               started_q,
  input logic [LVL_W-1:0]   rd_level,
  input logic [LINES*4-1:0] q_data,
  input logic [3:0]         q_fclk
);

  logic [3:0] age_q;

  always_ff @(posedge q_clk or negedge q_rst_n_s) begin
    if (!q_rst_n_s) begin
      age_q <= '0;
    end else if (age_q != 4'hF) begin
      age_q <= age_q + 4'd1;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge q_clk)
    !rst_n |-> (q_data == '0 && q_fclk == '0)); // R6

  AST_IDLE_DATA_ZERO: assert property (@(posedge q_clk) disable iff (!q_rst_n_s)
    !started_q |=> (q_data == '0)); // R7

  AST_START_STICKY: assert property (@(posedge q_clk) disable iff (!q_rst_n_s)
    started_q |=> started_q); // R7

  AST_NO_OVERFLOW: assert property (@(posedge q_clk) disable iff (!q_rst_n_s)
    rd_level <= LVL_W'(DEPTH)); // R8

  AST_FCLK_REPEAT: assert property (@(posedge q_clk) disable iff (!q_rst_n_s)
    (age_q >= 4'd8) |-> (q_fclk == $past(q_fclk, 7))); // R5

endmodule

bind tx_gearbox_7to4 tx_gearbox_7to4_chk #(.LINES(LINES), .DEPTH(DEPTH)) u_chk (
  .q_clk     (q_clk),
  .rst_n     (rst_n),
  .q_rst_n_s (q_rst_n_s),
  .started_q (started_q),
  .rd_level  (rd_level),
  .q_data    (q_data),
  .q_fclk    (q_fclk)
);

// File: tb/tx_gearbox_7to4_bench.sv
module tx_gearbox_7to4_bench;
  import tx_gbx_pkg::*;

  localparam int LINES     = 4;
  localparam int PX_PERIOD = 28;
  localparam int Q_PERIOD  = 16;
  localparam int NVEC      = 12;
  localparam int NDUT      = 2;
  localparam int WATCHDOG  = 40000 * Q_PERIOD;

  localparam logic [LINES*7-1:0] STIM [NVEC] = '{
    28'hA5C3E17, 28'h1234567, 28'hFEDCBA9, 28'h0000001,
    28'h8000000, 28'h5555555, 28'hAAAAAAA, 28'hFFFFFFF,
    28'h0F0F0F0, 28'h3C96A5E, 28'h7000000, 28'h0000000
  };

  logic px_clk = 1'b0;
  logic q_clk  = 1'b0;
  logic rst_n  = 1'b1;
  logic [LINES*7-1:0] px_word = '0;
  logic [LINES*4-1:0] q_data_s, q_data_l;
  logic [3:0]         q_fclk_s, q_fclk_l;

  always #(PX_PERIOD/2) px_clk = ~px_clk;
  always #(Q_PERIOD/2)  q_clk  = ~q_clk;

  tx_gearbox_7to4 #(.LINES(LINES), .PACKING(PACK_BY_SLOT)) u_tx_gearbox_7to4 (
    .px_clk (px_clk), .q_clk (q_clk), .rst_n (rst_n), .px_word (px_word),
    .q_data (q_data_s), .q_fclk (q_fclk_s)
  );

  tx_gearbox_7to4 #(.LINES(LINES), .PACKING(PACK_BY_LANE)) u_tx_gearbox_7to4_lane (
    .px_clk (px_clk), .q_clk (q_clk), .rst_n (rst_n), .px_word (px_word),
    .q_data (q_data_l), .q_fclk (q_fclk_l)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected symbol of line l for vector v, d=0 slot packing, d=1 lane packing
  function automatic logic [6:0] exp_sym(input int d, input int v, input int l);
    logic [6:0] w;
    for (int b = 0; b < 7; b++) begin
      w[b] = (d == 0) ? STIM[v][b*LINES + l] : STIM[v][l*7 + b];
    end
    return w;
  endfunction

  logic [6:0] clk_sr [NDUT];
  logic [6:0] dat_sr [NDUT][LINES];
  bit         locked [NDUT];
  bit         seen   [NDUT];
  int         phase  [NDUT];
  int         idx    [NDUT];

  task automatic clear_state();
    for (int d = 0; d < NDUT; d++) begin
      clk_sr[d] = '0;
      locked[d] = 1'b0;
      seen[d]   = 1'b0;
      phase[d]  = 0;
      idx[d]    = 0;
      for (int l = 0; l < LINES; l++) dat_sr[d][l] = '0;
    end
  endtask

  task automatic eval_frame(input int d);
    logic [27:0] act, exp;
    for (int l = 0; l < LINES; l++) act[l*7 +: 7] = dat_sr[d][l];
    if (!seen[d]) begin
      if (act != '0) begin
        for (int l = 0; l < LINES; l++) exp[l*7 +: 7] = exp_sym(d, 0, l);
        check(act == exp, (d == 0) ? "R7 R3 R4" : "R7 R2 R4", 32'(act), 32'(exp));
        seen[d] = 1'b1;
        idx[d]  = 1;
      end
    end else if (idx[d] < NVEC) begin
      for (int l = 0; l < LINES; l++) exp[l*7 +: 7] = exp_sym(d, idx[d], l);
      check(act == exp, (d == 0) ? "R3 R4" : "R2 R4", 32'(act), 32'(exp));
      idx[d]++;
    end else begin
      check(act == '0, "R1", 32'(act), 32'h0);
    end
  endtask

  task automatic take_slice(input int d, input logic [LINES*4-1:0] dat,
                            input logic [3:0] fc);
    for (int i = 3; i >= 0; i--) begin
      clk_sr[d] = {clk_sr[d][5:0], fc[i]};
      for (int l = 0; l < LINES; l++) dat_sr[d][l] = {dat_sr[d][l][5:0], dat[l*4 + i]};
      if (!locked[d]) begin
        if (clk_sr[d] == FRAME_PAT) begin
          locked[d] = 1'b1;
          phase[d]  = 0;
          eval_frame(d);
        end
      end else begin
        phase[d]++;
        if (phase[d] == 7) begin
          phase[d] = 0;
          check(clk_sr[d] == FRAME_PAT, "R5", 32'(clk_sr[d]), 32'(FRAME_PAT));
          eval_frame(d);
        end
      end
    end
  endtask

  always @(negedge q_clk) begin
    if (!rst_n) begin
      clear_state();
    end else begin
      take_slice(0, q_data_s, q_fclk_s);
      take_slice(1, q_data_l, q_fclk_l);
    end
  end

  task automatic run_table(input int lead);
    repeat (lead) @(negedge px_clk) px_word = '0;
    for (int v = 0; v < NVEC; v++) begin
      @(negedge px_clk) px_word = STIM[v];
    end
    @(negedge px_clk) px_word = '0;
  endtask

  task automatic first_slice_check();
    int n = 0;
    @(negedge q_clk);
    while (q_fclk_s == '0 && n < 20) begin
      @(negedge q_clk);
      n++;
    end
    check(q_fclk_s == 4'b1100, "R7", 32'(q_fclk_s), 32'hC);
    check(q_fclk_l == 4'b1100, "R7", 32'(q_fclk_l), 32'hC);
    check(q_data_s == '0 && q_data_l == '0, "R7", 32'({q_data_s, q_data_l}), 32'h0);
  endtask

  task automatic reset_zero_check();
    repeat (3) begin
      @(negedge q_clk);
      check(q_data_s == '0 && q_fclk_s == '0, "R6", 32'({q_data_s, q_fclk_s}), 32'h0);
      check(q_data_l == '0 && q_fclk_l == '0, "R6", 32'({q_data_l, q_fclk_l}), 32'h0);
    end
  endtask

  initial begin
    clear_state();
    #1 rst_n = 1'b0;
    reset_zero_check();
    @(negedge px_clk) rst_n = 1'b1;
    fork
      run_table(5);
      first_slice_check();
    join
    repeat (80) @(negedge px_clk);
    for (int d = 0; d < NDUT; d++) begin
      check(idx[d] == NVEC, "R1 R8", 32'(idx[d]), 32'(NVEC));
    end

    // Mid-run reset, then a burst that starts soon after release
    #5 rst_n = 1'b0;
    reset_zero_check();
    @(negedge px_clk) rst_n = 1'b1;
    fork
      run_table(2);
      first_slice_check();
    join
    repeat (80) @(negedge px_clk);
    for (int d = 0; d < NDUT; d++) begin
      check(idx[d] == NVEC, "R9 R1", 32'(idx[d]), 32'(NVEC));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(WATCHDOG);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule